// File: doc/BRIEF.md
# Threaded Stack Control Sequencer

This block is one node of a tree of control sequencers that coordinate stream-processing work. It runs small control programs held in a local program memory. No program counter steps through consecutive addresses. Every instruction word names the address of the instruction that follows it. Loop counters and other control variables are kept on an operand stack. The sequencer has no register file. Each instruction also has one command slot for each subordinate node. A slot that is not empty starts that child with a task number. The sequencer then waits until every child started by that instruction has reported completion.

A parent node starts a task by pulsing `start` with an entry address. The task runs until it threads to the end address, which is all ones. At that point `done` pulses for one cycle and the sequencer goes back to idle. The stack is not cleared between tasks. A new task works above the entries left by earlier tasks and is expected to remove whatever it pushed. The program memory is filled at boot through a write port while the sequencer is idle.

The control state machine has six states:
- IDLE waits for `start`.
- FETCH reads the current word.
- EXEC applies the stack operation, chooses the successor and issues child starts.
- WAIT holds until the dispatched children are done.
- FINISH raises `done`.
- HALT is entered on a stack fault and is left only by reset.

The transitions are:
- IDLE goes to FETCH on start.
- FETCH always goes to EXEC.
- EXEC goes to HALT on a fault, to WAIT if any slot is non-empty, to FINISH if the successor is the end address, and to FETCH otherwise.
- WAIT goes to FINISH or FETCH once all children are clear.
- FINISH goes to IDLE.

Top module: `thread_ctrl`

## Requirements
- R1: A `start` pulse while idle begins execution at `start_addr`. After each instruction, the next word fetched is the one at the address in bits [31:24], or at the conditional alternate (R3). The address is never incremented implicitly.
- R2: Bits [23:20] select the stack operation:
  - 0 leaves the stack unchanged.
  - 1 pushes the 8-bit immediate in bits [19:12].
  - 2 duplicates the top entry.
  - 3 removes the top entry.
  - 4 replaces the top two entries with second plus top.
  - 5 replaces the top two entries with second minus top.
  - 6 decrements the top entry in place.
  - 7 is the conditional thread.
  - Codes 8 to 15 act as 0.
  - Arithmetic wraps modulo 256.
  - `stack_depth` and `stack_top` show the entry count and the top value, with 0 when the stack is empty.
- R3: Opcode 7 removes the top entry. If that entry was zero, the successor is bits [19:12]. Otherwise the successor is bits [31:24].
- R4: Bits [3i+2:3i] form the slot for child i. A non-zero slot raises `child_start[i]` for exactly one cycle, in the execute cycle, with the slot value on the matching field of `child_task`. The sequencer does not advance until every child started by that instruction has pulsed `child_done`. A `child_done` from a child that was not started has no effect.
- R5: A successor address of 255 ends the task. `done` is high for exactly one cycle after the instruction completes, and `busy` is low from the following cycle.
- R6: The stack keeps its contents across tasks. A task that pushes and removes the same number of entries leaves `stack_depth` and `stack_top` as it found them.
- R7: Any of the following is a fault:
  - a push or duplicate onto 16 entries
  - a remove, decrement, duplicate or conditional thread on an empty stack
  - an add or subtract with fewer than two entries

  A fault leaves the stack unchanged, issues no child start, sets `err` until reset and stops execution with `busy` held high.
- R8: A write on the load port stores `load_data` at `load_addr` only while idle. A write while busy is ignored.
- R9: After reset, `busy`, `done`, `err`, `child_start` and `stack_depth` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_en | input | 1 | Program memory write strobe |
| load_addr | input | 8 | Program memory write address |
| load_data | input | 32 | Instruction word to store |
| start | input | 1 | Task start from the parent |
| start_addr | input | 8 | Task entry address |
| child_done | input | 4 | Completion pulses from the children |
| busy | output | 1 | A task is running or the sequencer is halted |
| done | output | 1 | One-cycle task completion pulse to the parent |
| err | output | 1 | Sticky stack fault flag |
| stack_depth | output | 5 | Number of stack entries |
| stack_top | output | 8 | Top stack entry, or 0 when empty |
| child_start | output | 4 | One-cycle start pulse per child |
| child_task | output | 12 | Task number per child, 3 bits each |

## Verification
A countdown loop built from push, duplicate, conditional thread and decrement tells a correct loop exit from an off-by-one exit by the number of child starts, which is three. It also shows whether the stack is left exactly where it was. A straight-line arithmetic task starts two children with different latencies while a third child sends done pulses it was never asked for. This separates waiting for all dispatched children from waiting for any one child, and shows whether stray completions are ignored. Further tasks cover the following:
- conditional threads that take each of their two branches
- a task that jumps backwards to a low address
- a load that arrives during a run
- an unbounded push loop that must halt after sixteen dispatches
- an add on an empty stack, which must fault without starting any child

// File: rtl/tc_pkg.sv
`timescale 1ns/1ps
package tc_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_NOP  = 4'd0,
        OP_PUSH = 4'd1,
        OP_DUP  = 4'd2,
        OP_DROP = 4'd3,
        OP_ADD  = 4'd4,
        OP_SUB  = 4'd5,
        OP_DEC  = 4'd6,
        OP_JZ   = 4'd7
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_EXEC,
        ST_WAIT,
        ST_FINISH,
        ST_HALT
    } state_e;

endpackage

// File: rtl/tc_progmem.sv
`timescale 1ns/1ps
module tc_progmem #(
    parameter int ADDR_W = 8,
    parameter int WORD_W = 32,
    localparam int ENTRIES = 2 ** ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] words [ENTRIES];

    always_ff @(posedge clk) begin
        if (we) begin
            words[waddr] <= wdata;
        end
        if (re) begin
            rdata <= words[raddr];
        end
    end

endmodule

// File: rtl/tc_stack.sv
`timescale 1ns/1ps
module tc_stack
    import tc_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int PW   = $clog2(DEPTH + 1),
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  op_e           op,
    input  logic [W-1:0]  imm,
    output logic          fault,
    output logic [W-1:0]  tos,
    output logic [PW-1:0] depth
);

    logic [W-1:0]  cells [DEPTH];
    logic [PW-1:0] sp_q, sp_d;
    logic [W-1:0]  nos, wr_val;
    logic [IW-1:0] wr_idx;
    logic          wr_en, empty, full, two;

    assign empty = (sp_q == '0);
    assign full  = (sp_q == PW'(DEPTH));
    assign two   = (sp_q >= PW'(2));
    assign tos   = empty ? '0 : cells[IW'(sp_q - PW'(1))];
    assign nos   = two   ? cells[IW'(sp_q - PW'(2))] : '0;
    assign depth = sp_q;

    always_comb begin
        unique case (op)
            OP_PUSH:                 fault = full;
            OP_DUP:                  fault = empty || full;
            OP_DROP, OP_DEC, OP_JZ:  fault = empty;
            OP_ADD, OP_SUB:          fault = !two;
            default:                 fault = 1'b0;
        endcase
    end

    always_comb begin
        wr_en  = 1'b0;
        wr_idx = IW'(sp_q);
        wr_val = imm;
        sp_d   = sp_q;
        if (en && !fault) begin
            unique case (op)
                OP_PUSH: begin
                    wr_en = 1'b1;
                    sp_d  = sp_q + PW'(1);
                end
                OP_DUP: begin
                    wr_en  = 1'b1;
                    wr_val = tos;
                    sp_d   = sp_q + PW'(1);
                end
                OP_DROP, OP_JZ: sp_d = sp_q - PW'(1);
                OP_ADD, OP_SUB: begin
                    wr_en  = 1'b1;
                    wr_idx = IW'(sp_q - PW'(2));
                    wr_val = (op == OP_ADD) ? nos + tos : nos - tos;
                    sp_d   = sp_q - PW'(1);
                end
                OP_DEC: begin
                    wr_en  = 1'b1;
                    wr_idx = IW'(sp_q - PW'(1));
                    wr_val = tos - W'(1);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[wr_idx] <= wr_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp_q <= '0;
        end else begin
            sp_q <= sp_d;
        end
    end

endmodule

// File: rtl/tc_child_track.sv
`timescale 1ns/1ps
module tc_child_track #(
    parameter int NCH    = 4,
    parameter int SLOT_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  issue,
    input  logic [NCH*SLOT_W-1:0] slots,
    input  logic [NCH-1:0]        child_done,
    output logic [NCH-1:0]        child_start,
    output logic [NCH*SLOT_W-1:0] child_task,
    output logic                  all_clear
);

    logic [NCH-1:0] pend_q;

    for (genvar i = 0; i < NCH; i++) begin : g_child
        logic active;
        assign active         = (slots[i*SLOT_W +: SLOT_W] != '0);
        assign child_start[i] = issue && active;
        assign child_task[i*SLOT_W +: SLOT_W] = issue ? slots[i*SLOT_W +: SLOT_W] : '0;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pend_q[i] <= 1'b0;
            end else if (issue) begin
                pend_q[i] <= active;
            end else if (child_done[i]) begin
                pend_q[i] <= 1'b0;
            end
        end
    end

    assign all_clear = ((pend_q & ~child_done) == '0);

endmodule

// File: rtl/thread_ctrl.sv
`timescale 1ns/1ps
module thread_ctrl
    import tc_pkg::*;
#(
    parameter int NCHILD      = 4,
    parameter int SLOT_W      = 3,
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 8,
    parameter int STACK_DEPTH = 16,
    localparam int SLOTS_W    = NCHILD * SLOT_W,
    localparam int IMM_LSB    = SLOTS_W,
    localparam int OP_LSB     = IMM_LSB + ADDR_W,
    localparam int NEXT_LSB   = OP_LSB + OP_W,
    localparam int INSTR_W    = NEXT_LSB + ADDR_W,
    localparam int DEPTH_W    = $clog2(STACK_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_en,
    input  logic [ADDR_W-1:0]  load_addr,
    input  logic [INSTR_W-1:0] load_data,
    input  logic               start,
    input  logic [ADDR_W-1:0]  start_addr,
    input  logic [NCHILD-1:0]  child_done,
    output logic               busy,
    output logic               done,
    output logic               err,
    output logic [DEPTH_W-1:0] stack_depth,
    output logic [DATA_W-1:0]  stack_top,
    output logic [NCHILD-1:0]  child_start,
    output logic [SLOTS_W-1:0] child_task
);

    localparam logic [ADDR_W-1:0] END_ADDR = '1;

    state_e              state_q, state_d;
    logic [ADDR_W-1:0]   pc_q, next_f, alt_f, tgt;
    logic [INSTR_W-1:0]  word;
    logic [SLOTS_W-1:0]  slots;
    op_e                 op;
    logic                fault, err_q, issue, all_clear, any_slot, stk_en, mem_we, mem_re;

    assign next_f   = word[NEXT_LSB +: ADDR_W];
    assign op       = op_e'(word[OP_LSB +: OP_W]);
    assign alt_f    = word[IMM_LSB +: ADDR_W];
    assign slots    = word[SLOTS_W-1:0];
    assign any_slot = (slots != '0);
    assign tgt      = (op == OP_JZ && stack_top == '0) ? alt_f : next_f;

    tc_progmem #(.ADDR_W(ADDR_W), .WORD_W(INSTR_W)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (load_addr),
        .wdata (load_data),
        .re    (mem_re),
        .raddr (pc_q),
        .rdata (word)
    );

    tc_stack #(.DEPTH(STACK_DEPTH), .W(DATA_W)) u_stack (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (stk_en),
        .op    (op),
        .imm   (DATA_W'(alt_f)),
        .fault (fault),
        .tos   (stack_top),
        .depth (stack_depth)
    );

    tc_child_track #(.NCH(NCHILD), .SLOT_W(SLOT_W)) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue       (issue),
        .slots       (slots),
        .child_done  (child_done),
        .child_start (child_start),
        .child_task  (child_task),
        .all_clear   (all_clear)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_FETCH;
            ST_FETCH:  state_d = ST_EXEC;
            ST_EXEC: begin
                if (fault)              state_d = ST_HALT;
                else if (any_slot)      state_d = ST_WAIT;
                else if (tgt == END_ADDR) state_d = ST_FINISH;
                else                    state_d = ST_FETCH;
            end
            ST_WAIT:   if (all_clear) state_d = (pc_q == END_ADDR) ? ST_FINISH : ST_FETCH;
            ST_FINISH: state_d = ST_IDLE;
            ST_HALT:   state_d = ST_HALT;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q  <= '0;
            err_q <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && start) begin
                pc_q <= start_addr;
            end else if (state_q == ST_EXEC && !fault) begin
                pc_q <= tgt;
            end
            if (state_q == ST_EXEC && fault) begin
                err_q <= 1'b1;
            end
        end
    end

    always_comb begin
        busy   = (state_q != ST_IDLE);
        done   = (state_q == ST_FINISH);
        err    = err_q;
        mem_we = load_en && (state_q == ST_IDLE);
        mem_re = (state_q == ST_FETCH);
        stk_en = (state_q == ST_EXEC);
        issue  = (state_q == ST_EXEC) && !fault;
    end

endmodule

// File: rtl/thread_ctrl_chk.sv
`timescale 1ns/1ps
module thread_ctrl_chk #(
    parameter int NCHILD      = 4,
    parameter int STACK_DEPTH = 16,
    localparam int DEPTH_W    = $clog2(STACK_DEPTH + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               busy,
    input logic               done,
    input logic               err,
    input logic [DEPTH_W-1:0] stack_depth,
    input logic [NCHILD-1:0]  child_start
);

    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r5_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    a_r7_halt_silent: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (child_start == '0 && busy));

    a_r4_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        (child_start != '0) |=> (child_start == '0));

    a_r4_start_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (child_start != '0) |-> busy);

    a_r2_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
        stack_depth <= DEPTH_W'(STACK_DEPTH));

    a_r6_idle_stack_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> $stable(stack_depth));

endmodule

bind thread_ctrl thread_ctrl_chk #(
    .NCHILD      (NCHILD),
    .STACK_DEPTH (STACK_DEPTH)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .done        (done),
    .err         (err),
    .stack_depth (stack_depth),
    .child_start (child_start)
);

// File: tb/thread_ctrl_tb_top.sv
`timescale 1ns/1ps
module thread_ctrl_tb_top;

    localparam int NCH = 4;
    localparam int SD  = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_en = 1'b0;
    logic [7:0]  load_addr = '0;
    logic [31:0] load_data = '0;
    logic        start = 1'b0;
    logic [7:0]  start_addr = '0;
    logic [3:0]  child_done = '0;
    logic        busy, done, err;
    logic [4:0]  stack_depth;
    logic [7:0]  stack_top;
    logic [3:0]  child_start;
    logic [11:0] child_task;

    always #2.5 clk = ~clk;

    thread_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
        .load_data(load_data), .start(start), .start_addr(start_addr),
        .child_done(child_done), .busy(busy), .done(done), .err(err),
        .stack_depth(stack_depth), .stack_top(stack_top),
        .child_start(child_start), .child_task(child_task)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit cmp_on = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at t=%0t", req, what, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference ----------------
    int          m_phase = 0;   // 0 idle 1 fetch 2 exec 3 wait 4 finish 5 halt
    int          m_pc = 0;
    logic [31:0] m_ir = '0;
    logic [31:0] m_prog [256];
    int          stk[$];
    bit          m_err = 1'b0;
    bit          m_pend [NCH];
    int          m_tgt, m_a, m_b;
    bit          m_any;

    function automatic bit m_fault();
        int n = stk.size();
        case (int'(m_ir[23:20]))
            1:       return n == SD;
            2:       return n == 0 || n == SD;
            3, 6, 7: return n == 0;
            4, 5:    return n < 2;
            default: return 1'b0;
        endcase
    endfunction

    function automatic int m_top();
        return (stk.size() > 0) ? stk[$] : 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_err = 0; stk.delete();
            for (int i = 0; i < NCH; i++) m_pend[i] = 0;
        end else begin
            case (m_phase)
                0: begin
                    if (load_en) m_prog[load_addr] = load_data;
                    if (start) begin m_pc = start_addr; m_phase = 1; end
                end
                1: begin m_ir = m_prog[m_pc]; m_phase = 2; end
                2: begin
                    if (m_fault()) begin
                        m_err = 1; m_phase = 5;
                    end else begin
                        m_tgt = m_ir[31:24];
                        case (int'(m_ir[23:20]))
                            1: stk.push_back(m_ir[19:12]);
                            2: stk.push_back(m_top());
                            3: m_a = stk.pop_back();
                            4: begin m_a = stk.pop_back(); m_b = stk.pop_back(); stk.push_back((m_b + m_a) & 255); end
                            5: begin m_a = stk.pop_back(); m_b = stk.pop_back(); stk.push_back((m_b - m_a) & 255); end
                            6: begin m_a = stk.pop_back(); stk.push_back((m_a - 1) & 255); end
                            7: begin m_a = stk.pop_back(); if (m_a == 0) m_tgt = m_ir[19:12]; end
                            default: ;
                        endcase
                        m_any = 0;
                        for (int i = 0; i < NCH; i++) begin
                            m_pend[i] = (m_ir[i*3 +: 3] != 0);
                            m_any |= m_pend[i];
                        end
                        m_pc = m_tgt;
                        if (m_any) m_phase = 3;
                        else m_phase = (m_tgt == 255) ? 4 : 1;
                    end
                end
                3: begin
                    m_any = 0;
                    for (int i = 0; i < NCH; i++) begin
                        if (child_done[i]) m_pend[i] = 0;
                        m_any |= m_pend[i];
                    end
                    if (!m_any) m_phase = (m_pc == 255) ? 4 : 1;
                end
                4: m_phase = 0;
                default: ;
            endcase
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            logic [3:0]  e_start;
            logic [11:0] e_task;
            e_start = '0; e_task = '0;
            if (m_phase == 2 && !m_fault()) begin
                for (int i = 0; i < NCH; i++) begin
                    if (m_ir[i*3 +: 3] != 0) begin
                        e_start[i] = 1'b1;
                        e_task[i*3 +: 3] = m_ir[i*3 +: 3];
                    end
                end
            end
            check(busy == (m_phase != 0), "R5", "busy", busy, m_phase != 0);
            check(done == (m_phase == 4), "R5", "done", done, m_phase == 4);
            check(err == m_err, "R7", "err", err, m_err);
            check(int'(stack_depth) == stk.size(), "R2", "stack_depth", stack_depth, stk.size());
            check(int'(stack_top) == m_top(), "R2", "stack_top", stack_top, m_top());
            check(child_start == e_start, "R4", "child_start", child_start, e_start);
            check(child_task == e_task, "R4", "child_task", child_task, e_task);
        end
    end

    // ---------------- child responders ----------------
    int lat [NCH] = '{1, 2, 6, 3};
    int rcnt [NCH] = '{0, 0, 0, 0};
    int dcnt [NCH] = '{0, 0, 0, 0};
    bit spur3 = 1'b0;
    logic [3:0] rd;

    always @(negedge clk) begin
        rd = '0;
        for (int i = 0; i < NCH; i++) begin
            if (!rst_n) rcnt[i] = 0;
            if (rcnt[i] > 0) begin
                rcnt[i]--;
                if (rcnt[i] == 0) rd[i] = 1'b1;
            end
            if (rst_n && child_start[i]) begin
                rcnt[i] = lat[i];
                dcnt[i]++;
            end
        end
        if (spur3) rd[3] = ~child_done[3];
        child_done = rd;
    end

    // ---------------- helpers ----------------
    function automatic logic [31:0] ins(input int nxt, input int op, input int imm,
                                        input int s0, input int s1, input int s2, input int s3);
        return {8'(nxt), 4'(op), 8'(imm), 3'(s3), 3'(s2), 3'(s1), 3'(s0)};
    endfunction

    task automatic load_word(input int a, input logic [31:0] d);
        @(negedge clk);
        load_en = 1'b1; load_addr = 8'(a); load_data = d;
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic clear_counts();
        for (int i = 0; i < NCH; i++) dcnt[i] = 0;
    endtask

    task automatic run(input int entry, input string req, output bit finished);
        clear_counts();
        finished = 1'b0;
        @(negedge clk);
        start = 1'b1; start_addr = 8'(entry);
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 2000 && !finished; k++) begin
            if (done) finished = 1'b1;
            else @(negedge clk);
        end
        check(finished, req, "task reached end", finished, 1);
        @(negedge clk);
    endtask

    task automatic run_to_fault(input int entry, input string req);
        bit seen;
        clear_counts();
        seen = 1'b0;
        @(negedge clk);
        start = 1'b1; start_addr = 8'(entry);
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 2000 && !seen; k++) begin
            if (err) seen = 1'b1;
            else @(negedge clk);
        end
        check(seen, req, "fault flag raised", seen, 1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    bit ok;
    int sd_before;

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state sampled while reset is held
        check(busy == 0 && done == 0 && err == 0, "R9", "status during reset", {busy, done, err}, 0);
        check(stack_depth == 0, "R9", "depth during reset", stack_depth, 0);
        check(child_start == 0, "R9", "child_start during reset", child_start, 0);
        rst_n = 1'b1;
        cmp_on = 1'b1;

        // countdown loop at 0x10 (R1, R2, R3, R4)
        load_word(8'h10, ins(8'h11, 1, 3, 0, 0, 0, 0));
        load_word(8'h11, ins(8'h12, 2, 0, 0, 0, 0, 0));
        load_word(8'h12, ins(8'h13, 7, 8'h14, 0, 0, 0, 0));
        load_word(8'h13, ins(8'h11, 6, 0, 5, 0, 0, 0));
        load_word(8'h14, ins(8'hFF, 3, 0, 0, 0, 0, 0));
        // arithmetic task with two children at 0x20 (R2, R4)
        load_word(8'h20, ins(8'h21, 1, 7, 1, 0, 3, 0));
        load_word(8'h21, ins(8'h22, 1, 5, 0, 0, 0, 0));
        load_word(8'h22, ins(8'h23, 5, 0, 0, 0, 0, 0));
        load_word(8'h23, ins(8'h24, 1, 2, 0, 0, 0, 0));
        load_word(8'h24, ins(8'h25, 4, 0, 0, 0, 0, 0));
        load_word(8'h25, ins(8'h26, 6, 0, 0, 0, 0, 0));
        load_word(8'h26, ins(8'h27, 2, 0, 0, 0, 0, 0));
        load_word(8'h27, ins(8'h28, 3, 0, 0, 0, 0, 0));
        load_word(8'h28, ins(8'hFF, 12, 0, 0, 0, 0, 0));
        // conditional taken at 0x30, not taken at 0x38 (R3)
        load_word(8'h30, ins(8'h31, 1, 0, 0, 0, 0, 0));
        load_word(8'h31, ins(8'h32, 7, 8'h40, 0, 0, 0, 0));
        load_word(8'h32, ins(8'hFF, 1, 9, 0, 0, 0, 0));
        load_word(8'h40, ins(8'hFF, 1, 4, 0, 0, 0, 0));
        load_word(8'h38, ins(8'h39, 1, 1, 0, 0, 0, 0));
        load_word(8'h39, ins(8'h3A, 7, 8'h40, 0, 0, 0, 0));
        load_word(8'h3A, ins(8'hFF, 1, 9, 0, 0, 0, 0));
        // backward thread at 0x70 -> 0x05 (R1)
        load_word(8'h70, ins(8'h05, 0, 0, 0, 0, 0, 0));
        load_word(8'h05, ins(8'hFF, 1, 6, 0, 0, 0, 0));
        // endless push loop at 0x50 (R7 overflow), add on empty at 0x60 (R7 underflow)
        load_word(8'h50, ins(8'h50, 1, 1, 0, 2, 0, 0));
        load_word(8'h60, ins(8'hFF, 4, 0, 0, 4, 0, 0));

        run(8'h10, "R4", ok);
        check(dcnt[0] == 3, "R4", "countdown dispatches", dcnt[0], 3);
        check(stack_depth == 0, "R6", "depth restored", stack_depth, 0);
        check(busy == 0, "R5", "idle after end", busy, 0);

        spur3 = 1'b1;
        run(8'h20, "R2", ok);
        spur3 = 1'b0;
        check(stack_depth == 1 && stack_top == 3, "R2", "arith result top", stack_top, 3);
        check(dcnt[0] == 1 && dcnt[2] == 1 && dcnt[3] == 0, "R4", "two-child dispatch", dcnt[0] + dcnt[2], 2);

        sd_before = stack_depth;
        fork
            run(8'h10, "R6", ok);
            begin
                repeat (4) @(negedge clk);
                load_word(8'h14, ins(8'h10, 1, 99, 7, 7, 7, 7));
            end
        join
        check(dcnt[0] == 3, "R8", "load while busy ignored", dcnt[0], 3);
        check(int'(stack_depth) == sd_before && stack_top == 3, "R6", "reentrant depth", stack_depth, sd_before);

        run(8'h30, "R3", ok);
        check(stack_depth == 2 && stack_top == 4, "R3", "zero takes alternate", stack_top, 4);
        run(8'h38, "R3", ok);
        check(stack_depth == 3 && stack_top == 9, "R3", "non-zero takes next", stack_top, 9);
        run(8'h70, "R1", ok);
        check(stack_depth == 4 && stack_top == 6, "R1", "backward thread", stack_top, 6);

        do_reset();
        check(stack_depth == 0 && err == 0, "R9", "depth after reset", stack_depth, 0);
        run_to_fault(8'h50, "R7");
        check(dcnt[1] == 16, "R7", "dispatches before overflow", dcnt[1], 16);
        check(stack_depth == 16 && busy == 1, "R7", "halted full", stack_depth, 16);
        repeat (6) @(negedge clk);
        check(err == 1 && dcnt[1] == 16, "R7", "sticky and silent", err, 1);

        do_reset();
        run_to_fault(8'h60, "R7");
        check(dcnt[1] == 0 && stack_depth == 0, "R7", "underflow no dispatch", dcnt[1], 0);

        repeat (4) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule